// File: doc/BRIEF.md
# Serial Slave Port for a Display Controller

This block is the serial command and data port of a display controller. An external host opens a transfer by pulling chip select low, clocks bytes in on a serial data line and reads bytes back on a serial output. The first byte of each transfer is a header. It holds a six-bit device address, a register-select flag and a direction flag. The port accepts the transfer only when the address matches its own. The lowest address bit comes from a strap input, so two such devices can share one bus.

On accepted write transfers, the port gathers pairs of bytes into 16-bit words. It hands each word to the controller core as a single-cycle strobe, labelled as an index, instruction or pixel write. Pixel words use a 5-6-5 colour layout and are widened to 6-6-6. On accepted read transfers, the port requests 16-bit words from the core and shifts them out. Pixel-memory reads first emit a fixed number of dummy bytes.

The serial clock, chip select and data input are synchronised into the system clock domain and sampled there. The serial clock therefore has to be slow relative to the system clock.

Top module: `lcd_serial_port`

## Requirements
- R1: After reset, and whenever chip select is high, the port behaves as idle. `sdo_oe`, `sdo`, `wr_stb` and `rd_req` are all low, and toggling `sclk` or `sdi` changes none of them.
- R2: Bits are taken on rising `sclk` edges, most significant bit first. The header byte is laid out as follows: bits 7..3 must equal 01110, bit 2 must equal `id_strap`, bit 1 is register select (RS) and bit 0 is direction (1 = read). If any of the six address bits differs, the rest of the transfer produces no strobe, no request and no output, and it leaves the stored index unchanged.
- R3: A write with RS=0 stores each word as the index. It emits `wr_stb` with `wr_kind` = 0 and `wr_data` = {2'b00, word}.
- R4: A write with RS=1 while the stored index differs from PIX_INDEX (default 16'h0022) emits `wr_kind` = 1 with `wr_data` = {2'b00, word}.
- R5: A write with RS=1 while the stored index equals PIX_INDEX emits `wr_kind` = 2. Its `wr_data` is {w[15:11], w[15], w[10:5], w[4:0], w[4]}.
- R6: After the header, the first byte of each pair is the upper half of the word and the second byte is the lower half. One strobe follows each completed pair, and a transfer may carry any number of words.
- R7: If chip select rises before a pair is complete, the partial word is dropped with no strobe. This also applies when chip select rises in the same system cycle as the final `sclk` rise of the pair.
- R8: A read with RS=0 issues `rd_req` with `rd_kind` = 0 (status). A read with RS=1 and an index other than PIX_INDEX uses `rd_kind` = 1. In both cases the data follows the header with no dummy bytes. Each returned word goes out MSB first, changing on falling `sclk` edges. A new request is issued after every two data bytes. `rd_data` must be valid at the clock edge that ends the `rd_req` cycle.
- R9: A read with RS=1 while the index equals PIX_INDEX uses `rd_kind` = 2. It first emits DUMMY_BYTES (default 4) zero bytes, then the returned words.
- R10: `sdo_oe` is high only after the header of a selected read and until chip select rises. It stays low on write transfers and on unselected ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock, idles high, half period at least 6 system cycles |
| sdi | input | 1 | Serial data in |
| id_strap | input | 1 | Lowest address bit of this device |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for `sdo` |
| wr_stb | output | 1 | One-cycle write strobe toward the core |
| wr_kind | output | 2 | Write type: 0 index, 1 instruction, 2 pixel |
| wr_data | output | 18 | Write word, widened for pixels |
| rd_req | output | 1 | One-cycle read request toward the core |
| rd_kind | output | 2 | Read type: 0 status, 1 instruction, 2 pixel |
| rd_data | input | 16 | Word returned by the core for a request |

## Verification
Two events can land in the same system cycle: the completion of a word's second byte and the deassertion of chip select. The bench provokes this by raising `cs_n` on the same cycle as the last `sclk` rise of a pair. It then expects no strobe, and it expects the stored index to be unchanged. It judges the index by the type the next RS=1 write receives. A cycle-level model in the bench holds the expected strobes in a queue and flags any strobe or request that it does not predict.

// File: rtl/lsp_pkg.sv
package lsp_pkg;

  typedef enum logic [1:0] {
    K_LOW   = 2'd0,
    K_INSTR = 2'd1,
    K_PIXEL = 2'd2
  } kind_t;

  typedef enum logic [1:0] {
    ST_START,
    ST_WRITE,
    ST_READ,
    ST_SKIP
  } state_t;

  function automatic logic [17:0] widen565(input logic [15:0] w);
    return {w[15:11], w[15], w[10:5], w[4:0], w[4]};
  endfunction

endpackage

// File: rtl/lsp_sync.sv
module lsp_sync #(
  parameter int          W       = 3,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES+1];

  assign chain[0] = d;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[i+1] <= RST_VAL;
      else     chain[i+1] <= chain[i];
    end
  end

  assign q = chain[STAGES];
endmodule

// File: rtl/lsp_byte_rx.sv
module lsp_byte_rx #(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          active,
  input  logic          sample,
  input  logic          bit_in,
  output logic          done,
  output logic [BW-1:0] value
);
  localparam int CW = $clog2(BW);

  logic [CW-1:0] cnt;
  logic [BW-1:0] sh;

  always_ff @(posedge clk) begin
    done <= 1'b0;
    if (rst) begin
      cnt   <= '0;
      sh    <= '0;
      value <= '0;
    end else if (!active) begin
      cnt <= '0;
      sh  <= '0;
    end else if (sample) begin
      sh <= {sh[BW-2:0], bit_in};
      if (cnt == CW'(BW - 1)) begin
        cnt   <= '0;
        done  <= 1'b1;
        value <= {sh[BW-2:0], bit_in};
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/lsp_tx_shift.sv
module lsp_tx_shift #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  output logic         bit_out
);
  logic [W-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      sh      <= '0;
      bit_out <= 1'b0;
    end else if (load) begin
      sh <= load_val;
    end else if (shift) begin
      bit_out <= sh[W-1];
      sh      <= {sh[W-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/lcd_serial_port.sv
module lcd_serial_port
  import lsp_pkg::*;
#(
  parameter logic [4:0]  ADDR_HI     = 5'b01110,
  parameter logic [15:0] PIX_INDEX   = 16'h0022,
  parameter int          DUMMY_BYTES = 4,
  parameter int          SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cs_n,
  input  logic        sclk,
  input  logic        sdi,
  input  logic        id_strap,
  output logic        sdo,
  output logic        sdo_oe,
  output logic        wr_stb,
  output logic [1:0]  wr_kind,
  output logic [17:0] wr_data,
  output logic        rd_req,
  output logic [1:0]  rd_kind,
  input  logic [15:0] rd_data
);
  localparam int BW  = 8;
  localparam int WW  = 2 * BW;
  localparam int DCW = $clog2(DUMMY_BYTES + 1) < 1 ? 1 : $clog2(DUMMY_BYTES + 1);

  logic [2:0]    s3;
  logic          cs_s, sclk_s, sdi_s, sclk_d;
  logic          rise, fall;
  logic          byte_done;
  logic [BW-1:0] byte_val;
  logic [BW-1:0] hi_q;
  logic [WW-1:0] index_q;
  logic [DCW-1:0] dcnt;
  logic          half, rs_q, pix_sel, addr_ok;
  state_t        st;

  lsp_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)) u_sync (
    .clk(clk), .rst(rst), .d({cs_n, sclk, sdi}), .q(s3)
  );

  assign cs_s    = s3[2];
  assign sclk_s  = s3[1];
  assign sdi_s   = s3[0];
  assign rise    = sclk_s & ~sclk_d;
  assign fall    = ~sclk_s & sclk_d;
  assign pix_sel = (index_q == PIX_INDEX);
  assign addr_ok = (byte_val[7:3] == ADDR_HI) && (byte_val[2] == id_strap);

  lsp_byte_rx #(.BW(BW)) u_rx (
    .clk(clk), .rst(rst), .active(~cs_s), .sample(rise), .bit_in(sdi_s),
    .done(byte_done), .value(byte_val)
  );

  always_ff @(posedge clk) begin
    wr_stb <= 1'b0;
    rd_req <= 1'b0;
    if (rst) begin
      st      <= ST_START;
      sclk_d  <= 1'b1;
      rs_q    <= 1'b0;
      half    <= 1'b0;
      hi_q    <= '0;
      dcnt    <= '0;
      index_q <= '0;
      wr_kind <= K_LOW;
      wr_data <= '0;
      rd_kind <= K_LOW;
      sdo_oe  <= 1'b0;
    end else begin
      sclk_d <= sclk_s;
      sdo_oe <= ~cs_s && (st == ST_READ);
      if (cs_s) begin
        st   <= ST_START;
        half <= 1'b0;
        dcnt <= '0;
      end else if (byte_done) begin
        case (st)
          ST_START: begin
            half <= 1'b0;
            rs_q <= byte_val[1];
            if (!addr_ok) begin
              st <= ST_SKIP;
            end else if (byte_val[0]) begin
              st <= ST_READ;
              if (!byte_val[1])  rd_kind <= K_LOW;
              else if (pix_sel)  rd_kind <= K_PIXEL;
              else               rd_kind <= K_INSTR;
              if (byte_val[1] && pix_sel && DUMMY_BYTES > 0) dcnt <= DCW'(DUMMY_BYTES);
              else                                          rd_req <= 1'b1;
            end else begin
              st <= ST_WRITE;
            end
          end
          ST_WRITE: begin
            if (!half) begin
              hi_q <= byte_val;
              half <= 1'b1;
            end else begin
              half   <= 1'b0;
              wr_stb <= 1'b1;
              if (!rs_q) begin
                wr_kind <= K_LOW;
                wr_data <= {2'b00, hi_q, byte_val};
                index_q <= {hi_q, byte_val};
              end else if (pix_sel) begin
                wr_kind <= K_PIXEL;
                wr_data <= widen565({hi_q, byte_val});
              end else begin
                wr_kind <= K_INSTR;
                wr_data <= {2'b00, hi_q, byte_val};
              end
            end
          end
          ST_READ: begin
            if (dcnt != '0) begin
              dcnt <= dcnt - 1'b1;
              if (dcnt == DCW'(1)) rd_req <= 1'b1;
            end else begin
              half <= ~half;
              if (half) rd_req <= 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  lsp_tx_shift #(.W(WW)) u_tx (
    .clk(clk), .rst(rst), .clear(cs_s), .load(rd_req), .load_val(rd_data),
    .shift(fall), .bit_out(sdo)
  );
endmodule

// File: rtl/lsp_checker.sv
module lsp_checker (
  input logic        clk,
  input logic        rst,
  input logic        cs_n,
  input logic        sclk,
  input logic        sdi,
  input logic        id_strap,
  input logic        sdo,
  input logic        sdo_oe,
  input logic        wr_stb,
  input logic [1:0]  wr_kind,
  input logic [17:0] wr_data,
  input logic        rd_req,
  input logic [1:0]  rd_kind,
  input logic [15:0] rd_data
);
  // R1: a chip select held high for several cycles leaves the port quiet
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3) && $past(cs_n, 4)
      |-> !sdo_oe && !wr_stb && !rd_req);

  // R2: only defined type codes ever reach the core
  a_r2_kind_legal: assert property (@(posedge clk) disable iff (rst)
    (wr_stb |-> wr_kind != 2'd3) and (rd_req |-> rd_kind != 2'd3));

  // R3: index and instruction words carry no widening bits
  a_r3_narrow_words: assert property (@(posedge clk) disable iff (rst)
    wr_stb && (wr_kind != 2'd2) |-> wr_data[17:16] == 2'b00);

  // R5: widened red and blue fields repeat their top bit at the bottom
  a_r5_widen_copy: assert property (@(posedge clk) disable iff (rst)
    wr_stb && (wr_kind == 2'd2) |-> (wr_data[12] == wr_data[17]) && (wr_data[0] == wr_data[5]));

  // R6: a word takes two bytes, so strobes are never back to back
  a_r6_strobe_spacing: assert property (@(posedge clk) disable iff (rst)
    wr_stb |=> !wr_stb);

  // R8: read requests are single-cycle pulses
  a_r8_req_pulse: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> !rd_req);

  // R10: a write strobe never coincides with an enabled output
  a_r10_no_oe_on_write: assert property (@(posedge clk) disable iff (rst)
    wr_stb |-> !sdo_oe);
endmodule

bind lcd_serial_port lsp_checker u_chk (.*);

// File: tb/lcd_serial_port_test.sv
module lcd_serial_port_test;
  localparam int H  = 8;
  localparam int WD = 150000;

  logic        clk = 1'b0, rst = 1'b1;
  logic        cs_n = 1'b1, sclk = 1'b1, sdi = 1'b0, id_strap = 1'b1;
  logic        sdo, sdo_oe, wr_stb, rd_req;
  logic [1:0]  wr_kind, rd_kind;
  logic [17:0] wr_data;
  logic [15:0] rd_data = '0;

  always #2 clk = ~clk;

  lcd_serial_port uut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .sdi(sdi), .id_strap(id_strap),
    .sdo(sdo), .sdo_oe(sdo_oe), .wr_stb(wr_stb), .wr_kind(wr_kind), .wr_data(wr_data),
    .rd_req(rd_req), .rd_kind(rd_kind), .rd_data(rd_data)
  );

  int          checks = 0, errors = 0, served = 0;
  string       tag = "R1";
  logic [19:0] expw[$];
  logic [19:0] e;
  logic [7:0]  txq[$];
  logic [7:0]  rxq[$];
  bit          rd_ok = 1'b0, exp_oe = 1'b0;
  logic [1:0]  exp_rk = 2'd0;

  function automatic logic [15:0] rword(int k);
    return 16'hC3A5 ^ 16'(k * 32'h1357);
  endfunction

  function automatic logic [17:0] px(logic [15:0] w);
    logic [5:0] r6, b6;
    r6 = {w[15:11], w[15]};
    b6 = {w[4:0], w[4]};
    return {r6, w[10:5], b6};
  endfunction

  function automatic logic [7:0] sb(logic idb, logic rs, logic rw);
    return {5'b01110, idb, rs, rw};
  endfunction

  task automatic chk(bit ok, string r, logic [31:0] act, logic [31:0] exv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exv);
    end
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push_word(logic [15:0] w);
    txq.push_back(w[15:8]);
    txq.push_back(w[7:0]);
  endtask

  task automatic xfer(logic [7:0] hdr, int nbits, bit coincide);
    logic [7:0] rb;
    int total;
    total = 8 + nbits;
    rb = '0;
    rxq.delete();
    cs_n = 1'b0;
    wait_clk(H);
    for (int i = 0; i < total; i++) begin
      int  j;
      bit  b;
      j = i - 8;
      if (i < 8) b = hdr[7 - i];
      else if (j / 8 < txq.size()) b = txq[j / 8][7 - (j % 8)];
      else b = 1'b0;
      sclk = 1'b0;
      sdi  = b;
      wait_clk(H);
      if (i >= 8) begin
        rb = {rb[6:0], sdo};
        if ((j % 8) == 0) chk(sdo_oe == exp_oe, "R10", sdo_oe, exp_oe);
      end
      sclk = 1'b1;
      if (coincide && i == total - 1) cs_n = 1'b1;
      wait_clk(H);
      if (i >= 8 && (j % 8) == 7) rxq.push_back(rb);
    end
    if (!coincide) begin
      wait_clk(H);
      cs_n = 1'b1;
    end
    wait_clk(4 * H);
    txq.delete();
  endtask

  // reference model: every strobe and request is checked against prediction
  always @(negedge clk) begin
    if (!rst) begin
      if (wr_stb) begin
        if (expw.size() == 0) chk(1'b0, tag, {12'b0, wr_kind, wr_data}, 32'h0);
        else begin
          e = expw.pop_front();
          chk({wr_kind, wr_data} == e, tag, {12'b0, wr_kind, wr_data}, {12'b0, e});
        end
      end
      if (rd_req) begin
        chk(rd_ok && (rd_kind == exp_rk), tag, {30'b0, rd_kind}, {30'b0, exp_rk});
        rd_data <= rword(served);
        served++;
      end
    end
  end

  task automatic summary;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (WD) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    int base;
    wait_clk(10);
    rst = 1'b0;
    wait_clk(2);
    // R1 reset state
    chk(!sdo_oe && !sdo && !wr_stb && !rd_req, "R1",
        {sdo_oe, sdo, wr_stb, rd_req}, 4'b0);
    // R1 bus activity with chip select high
    for (int k = 0; k < 20; k++) begin
      sclk = ~sclk; sdi = k[1];
      wait_clk(3);
    end
    sclk = 1'b1;
    wait_clk(6);
    chk(!sdo_oe && !sdo, "R1", {sdo_oe, sdo}, 2'b0);

    // R3 index write
    tag = "R3";
    push_word(16'h0003);
    expw.push_back({2'd0, 18'h00003});
    xfer(sb(1, 0, 0), 16, 0);
    chk(expw.size() == 0, "R3", expw.size(), 0);

    // R4 and R6 two instruction words in one transfer
    tag = "R6";
    push_word(16'h1234); push_word(16'hBEEF);
    expw.push_back({2'd1, 18'h01234});
    expw.push_back({2'd1, 18'h0BEEF});
    xfer(sb(1, 1, 0), 32, 0);
    chk(expw.size() == 0, "R4", expw.size(), 0);

    // R5 pixel writes after selecting the pixel index
    tag = "R5";
    push_word(16'h0022);
    expw.push_back({2'd0, 18'h00022});
    xfer(sb(1, 0, 0), 16, 0);
    push_word(16'hF81F); push_word(16'h07E0); push_word(16'h8410);
    expw.push_back({2'd2, px(16'hF81F)});
    expw.push_back({2'd2, px(16'h07E0)});
    expw.push_back({2'd2, px(16'h8410)});
    xfer(sb(1, 1, 0), 48, 0);
    chk(expw.size() == 0, "R5", expw.size(), 0);

    // R2 address mismatch: wrong strap bit, wrong upper bits
    tag = "R2";
    exp_oe = 1'b0;
    push_word(16'h0005);
    xfer(sb(0, 0, 0), 16, 0);
    push_word(16'h0005);
    xfer(8'b01100_1_0_0, 16, 0);
    rd_ok = 1'b0;
    xfer(sb(0, 1, 1), 16, 0);
    chk(rxq[0] == 8'h00 && rxq[1] == 8'h00, "R2", {rxq[0], rxq[1]}, 16'h0);
    // index must still be the pixel one
    push_word(16'h001F);
    expw.push_back({2'd2, px(16'h001F)});
    xfer(sb(1, 1, 0), 16, 0);
    chk(expw.size() == 0, "R2", expw.size(), 0);
    // strap low selects the other address
    id_strap = 1'b0;
    push_word(16'h7C00);
    expw.push_back({2'd2, px(16'h7C00)});
    xfer(sb(0, 1, 0), 16, 0);
    chk(expw.size() == 0, "R2", expw.size(), 0);
    id_strap = 1'b1;

    // R7 partial words
    tag = "R7";
    push_word(16'h0005);
    xfer(sb(1, 0, 0), 12, 0);
    push_word(16'h0123); txq.push_back(8'hAA);
    expw.push_back({2'd2, px(16'h0123)});
    xfer(sb(1, 1, 0), 24, 0);
    // chip select rises with the final clock edge of the word
    push_word(16'h0007);
    xfer(sb(1, 0, 0), 16, 1);
    push_word(16'hFFFF);
    expw.push_back({2'd2, px(16'hFFFF)});
    xfer(sb(1, 1, 0), 16, 0);
    chk(expw.size() == 0, "R7", expw.size(), 0);

    // R8 status read, two words, no dummy bytes
    tag = "R8";
    rd_ok = 1'b1; exp_rk = 2'd0; exp_oe = 1'b1;
    base = served;
    xfer(sb(1, 0, 1), 32, 0);
    chk({rxq[0], rxq[1]} == rword(base), "R8", {rxq[0], rxq[1]}, rword(base));
    chk({rxq[2], rxq[3]} == rword(base + 1), "R8", {rxq[2], rxq[3]}, rword(base + 1));

    // R9 pixel read with dummy bytes
    tag = "R9";
    exp_rk = 2'd2;
    base = served;
    xfer(sb(1, 1, 1), 64, 0);
    for (int k = 0; k < 4; k++) chk(rxq[k] == 8'h00, "R9", rxq[k], 8'h00);
    chk({rxq[4], rxq[5]} == rword(base), "R9", {rxq[4], rxq[5]}, rword(base));
    chk({rxq[6], rxq[7]} == rword(base + 1), "R9", {rxq[6], rxq[7]}, rword(base + 1));

    // R8 instruction read after moving the index away
    tag = "R8";
    rd_ok = 1'b0; exp_oe = 1'b0;
    push_word(16'h0005);
    expw.push_back({2'd0, 18'h00005});
    xfer(sb(1, 0, 0), 16, 0);
    rd_ok = 1'b1; exp_rk = 2'd1; exp_oe = 1'b1;
    base = served;
    xfer(sb(1, 1, 1), 16, 0);
    chk({rxq[0], rxq[1]} == rword(base), "R8", {rxq[0], rxq[1]}, rword(base));
    rd_ok = 1'b0; exp_oe = 1'b0;
    wait_clk(4);
    chk(!sdo_oe && !sdo, "R10", {sdo_oe, sdo}, 2'b0);

    summary();
  end
endmodule